// File: doc/BRIEF.md
# Bayer byte-stream to RGB pixel formatter

This block sits behind a frame buffer that holds raw colour-filter samples from an image sensor, one byte per sample, and turns that byte stream into packed 24-bit RGB pixels. The data read back from the buffer starts with a run of unstable bytes. The block therefore first hunts for a three-byte synchronisation marker: a marker byte, one byte of any value, then the marker byte again. The byte that follows the second marker byte is the first sample of the frame.

Once synchronised, the block takes the samples in groups of four, ordered green, blue, green, red. It halves each green with a right shift and adds the two halves. It then presents one pixel with red in the top byte, the averaged green in the middle byte and blue in the bottom byte. Both sides use valid/ready handshakes. A column and row counter tags the last pixel of every row and the last pixel of the frame. After the last pixel of a frame has been formed, the block goes back to hunting for a marker.

The frame size defaults to 176 pixels by 144 rows and can be set by parameter. The marker value defaults to 0x10.

Top module: `bayer_rgb_formatter`

## Requirements
- R1: After reset, `out_valid`, `out_eol` and `out_eof` are low, `in_ready` is high and the block is hunting for a marker.
- R2: While hunting, every offered byte is accepted (`in_ready` high) and discarded; no pixel is produced from it.
- R3: The marker is found by a streaming match at any byte position: the current byte equals MARK (default 0x10) and the byte accepted two bytes earlier also equals MARK, with the middle byte of any value. The next accepted byte is the first sample of the frame.
- R4: Overlapping candidates are matched correctly. For example, the stream 0x10, 0x10, x, 0x10 completes the marker on its fourth byte.
- R5: After synchronisation, accepted bytes form groups in the fixed order G1, B, G2, R. Each group yields exactly one output pixel.
- R6: The output pixel is packed as `out_rgb[23:16]` = R, `out_rgb[15:8]` = (G1 >> 1) + (G2 >> 1), and `out_rgb[7:0]` = B.
- R7: `out_eol` is high with the pixel in column COLS-1 of every row (pixels are numbered from 0 in raster order).
- R8: `out_eof` (together with `out_eol`) is high with pixel COLS*ROWS-1. The byte accepted after that pixel's red byte is searched for a new marker and is not treated as a sample.
- R9: While `out_valid` is high and `out_ready` is low, the output pixel and its flags hold steady. A red byte that would complete a new group is not accepted (`in_ready` low) until the output slot frees. The three earlier bytes of the group are still accepted.
- R10: `out_valid` is high in the cycle after the red byte of a group is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| in_data | input | CH_W (8) | Raw sample byte from the frame buffer |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_rgb | output | 3*CH_W (24) | Packed pixel: red, averaged green, blue from high to low byte |
| out_eol | output | 1 | Pixel is the last of its row |
| out_eof | output | 1 | Pixel is the last of the frame |

## Verification
The bench places marker-like bytes in the junk run: a lone 0x10 followed by other bytes, and the overlapping pattern 0x10, 0x10, x, 0x10. A detector that used a fixed offset or restarted wrongly would lock one byte off, and every later pixel would come out garbled. The pixel table uses greens with odd values and greens at full scale. This exposes a design that averages before shifting, drops the shift, or swaps red and blue. After the last pixel of a frame, the bench sends ordinary bytes and checks that nothing comes out; a design that stayed locked would turn those bytes into a phantom pixel. A directed stall holds the output with a completed group waiting, which catches a design that overwrites the held pixel or swallows the waiting red byte.

// File: rtl/bfmt_pkg.sv
package bfmt_pkg;

    // Width of one colour sample byte on the input side.
    parameter int unsigned CH_W = 8;

    // Operating mode of the formatter.
    typedef enum logic {
        MODE_SEEK  = 1'b0,
        MODE_PIXEL = 1'b1
    } fmt_mode_e;

    // Number of samples that make one output pixel.
    localparam int unsigned GROUP_BYTES = 4;

    // Position of each sample within a group.
    localparam int unsigned SLOT_G1 = 0;
    localparam int unsigned SLOT_B  = 1;
    localparam int unsigned SLOT_G2 = 2;
    localparam int unsigned SLOT_R  = 3;

endpackage

// File: rtl/bfmt_marker_seek.sv
// Streaming detector for the pattern MARK, any byte, MARK.
// It keeps one flag for each of the two previous accepted bytes. The pattern is
// complete when the current byte and the byte two positions back both match.
// Overlapping candidates therefore need no special restart path.
module bfmt_marker_seek #(
    parameter int unsigned      CH_W = 8,
    parameter logic [CH_W-1:0]  MARK = 'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_fire,
    input  logic [CH_W-1:0] byte_data,
    output logic            hit
);

    typedef struct packed {
        logic older;   // byte two positions back matched MARK
        logic newer;   // previous byte matched MARK
    } seek_t;

    seek_t s_d, s_q;
    logic  cur_mark;

    always_comb begin
        s_d      = s_q;
        cur_mark = (byte_data == MARK);
        hit      = byte_fire && cur_mark && s_q.older;
        if (byte_fire) begin
            if (hit) begin
                s_d = '0;
            end else begin
                s_d.older = s_q.newer;
                s_d.newer = cur_mark;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/bfmt_quad_pack.sv
// Collects G1, B, G2 and combines them with the arriving R byte into one pixel.
module bfmt_quad_pack
    import bfmt_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            byte_fire,
    input  logic [CH_W-1:0] byte_data,
    output logic            grp_last,
    output logic            grp_done,
    output logic [CH_W-1:0] pix_r,
    output logic [CH_W-1:0] pix_g,
    output logic [CH_W-1:0] pix_b
);

    localparam int unsigned PH_W = $clog2(GROUP_BYTES);
    localparam logic [PH_W-1:0] PH_G1 = PH_W'(SLOT_G1);
    localparam logic [PH_W-1:0] PH_B  = PH_W'(SLOT_B);
    localparam logic [PH_W-1:0] PH_G2 = PH_W'(SLOT_G2);
    localparam logic [PH_W-1:0] PH_R  = PH_W'(SLOT_R);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [CH_W-1:0] g1;
        logic [CH_W-1:0] b;
        logic [CH_W-1:0] g2;
    } pack_t;

    pack_t p_d, p_q;
    logic [CH_W-1:0] half_g1, half_g2;

    always_comb begin
        p_d      = p_q;
        grp_last = (p_q.phase == PH_R);
        grp_done = byte_fire && grp_last;

        // Each green is halved on its own, so the sum never exceeds CH_W bits.
        half_g1 = p_q.g1 >> 1;
        half_g2 = p_q.g2 >> 1;
        pix_r   = byte_data;
        pix_g   = half_g1 + half_g2;
        pix_b   = p_q.b;

        if (restart) begin
            p_d.phase = PH_G1;
        end else if (byte_fire) begin
            unique case (p_q.phase)
                PH_G1:   p_d.g1 = byte_data;
                PH_B:    p_d.b  = byte_data;
                PH_G2:   p_d.g2 = byte_data;
                default: ;
            endcase
            p_d.phase = p_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/bfmt_raster_pos.sv
// Column and row position of the next pixel to be formed within the frame.
module bfmt_raster_pos #(
    parameter int unsigned COLS = 176,
    parameter int unsigned ROWS = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic at_eol,
    output logic at_eof
);

    localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        at_eol = (r_q.col == COL_LAST);
        at_eof = at_eol && (r_q.row == ROW_LAST);
        if (restart) begin
            r_d = '0;
        end else if (step) begin
            if (at_eof) begin
                r_d = '0;
            end else if (at_eol) begin
                r_d.col = '0;
                r_d.row = r_q.row + 1'b1;
            end else begin
                r_d.col = r_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/bayer_rgb_formatter.sv
module bayer_rgb_formatter
    import bfmt_pkg::*;
#(
    parameter int unsigned      CH_W = bfmt_pkg::CH_W,
    parameter int unsigned      COLS = 176,
    parameter int unsigned      ROWS = 144,
    parameter logic [CH_W-1:0]  MARK = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CH_W-1:0]   in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3*CH_W-1:0] out_rgb,
    output logic              out_eol,
    output logic              out_eof
);

    localparam int unsigned RGB_W = 3 * CH_W;

    typedef struct packed {
        fmt_mode_e        mode;
        logic             valid;
        logic [RGB_W-1:0] rgb;
        logic             eol;
        logic             eof;
    } top_t;

    top_t t_d, t_q;

    logic            synced;
    logic            byte_fire;
    logic            seek_fire;
    logic            pix_fire;
    logic            hit;
    logic            grp_last;
    logic            grp_done;
    logic            at_eol;
    logic            at_eof;
    logic            slot_busy;
    logic [CH_W-1:0] pix_r, pix_g, pix_b;

    assign synced    = (t_q.mode == MODE_PIXEL);
    assign slot_busy = t_q.valid && !out_ready;
    assign in_ready  = !synced || !(grp_last && slot_busy);
    assign byte_fire = in_valid && in_ready;
    assign seek_fire = byte_fire && !synced;
    assign pix_fire  = byte_fire && synced;

    bfmt_marker_seek #(
        .CH_W (CH_W),
        .MARK (MARK)
    ) u_seek (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (seek_fire),
        .byte_data (in_data),
        .hit       (hit)
    );

    bfmt_quad_pack #(
        .CH_W (CH_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (hit),
        .byte_fire (pix_fire),
        .byte_data (in_data),
        .grp_last  (grp_last),
        .grp_done  (grp_done),
        .pix_r     (pix_r),
        .pix_g     (pix_g),
        .pix_b     (pix_b)
    );

    bfmt_raster_pos #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hit),
        .step    (grp_done),
        .at_eol  (at_eol),
        .at_eof  (at_eof)
    );

    always_comb begin
        t_d = t_q;
        if (t_q.valid && out_ready) begin
            t_d.valid = 1'b0;
        end
        if (grp_done) begin
            t_d.valid = 1'b1;
            t_d.rgb   = {pix_r, pix_g, pix_b};
            t_d.eol   = at_eol;
            t_d.eof   = at_eof;
        end
        unique case (t_q.mode)
            MODE_SEEK:  if (hit) t_d.mode = MODE_PIXEL;
            MODE_PIXEL: if (grp_done && at_eof) t_d.mode = MODE_SEEK;
            default:    t_d.mode = MODE_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{mode: MODE_SEEK, valid: 1'b0, rgb: '0, eol: 1'b0, eof: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign out_valid = t_q.valid;
    assign out_rgb   = t_q.rgb;
    assign out_eol   = t_q.valid && t_q.eol;
    assign out_eof   = t_q.valid && t_q.eof;

endmodule

// File: rtl/bfmt_checker.sv
module bfmt_checker #(
    parameter int unsigned RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RGB_W-1:0] out_rgb,
    input logic             out_eol,
    input logic             out_eof,
    input logic             synced,
    input logic             grp_last
);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_eol) && $stable(out_eof))); // R9

    AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> out_eol); // R8

    AST_SEEK_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> in_ready); // R2

    AST_PIXEL_AFTER_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && synced && grp_last) |=> out_valid); // R10

endmodule

bind bayer_rgb_formatter bfmt_checker #(.RGB_W(RGB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb),
    .out_eol   (out_eol),
    .out_eof   (out_eof),
    .synced    (synced),
    .grp_last  (grp_last)
);

// File: tb/tb_bayer_rgb_formatter.sv
module tb_bayer_rgb_formatter;

    localparam int CLK_PERIOD = 10;
    localparam int COLS       = 4;
    localparam int ROWS       = 3;
    localparam int NPIX       = COLS * ROWS;

    // Pixel groups as {G1, B, G2, R}, streamed in that byte order.
    localparam logic [31:0] PIX_TAB [NPIX] = '{
        32'hFF_11_FF_22, 32'h01_80_01_7F, 32'h03_00_05_FF, 32'h10_10_10_10,
        32'hFE_AA_02_55, 32'h00_FF_00_00, 32'h81_3C_7F_C3, 32'h64_01_C8_02,
        32'h10_20_30_40, 32'hFF_00_00_FF, 32'h55_AA_AB_5A, 32'h99_66_77_88
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;
    logic        out_eol;
    logic        out_eof;

    logic        bp_auto = 1'b0;
    logic        ready_man = 1'b1;
    logic        pat_q = 1'b1;
    int          pat_cnt = 0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] exp_rgb [64];
    logic        exp_eol [64];
    logic        exp_eof [64];
    int          exp_wr = 0;
    int          exp_rd = 0;

    assign out_ready = bp_auto ? pat_q : ready_man;

    bayer_rgb_formatter #(
        .CH_W (8),
        .COLS (COLS),
        .ROWS (ROWS),
        .MARK (8'h10)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_rgb   (out_rgb),
        .out_eol   (out_eol),
        .out_eof   (out_eof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        pat_cnt <= pat_cnt + 1;
        pat_q   <= (pat_cnt % 3) != 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [31:0] grp, input bit eol, input bit eof);
        logic [7:0] g1, b, g2, r;
        g1 = grp[31:24]; b = grp[23:16]; g2 = grp[15:8]; r = grp[7:0];
        exp_rgb[exp_wr] = {r, 8'((g1 / 2) + (g2 / 2)), b};
        exp_eol[exp_wr] = eol;
        exp_eof[exp_wr] = eof;
        exp_wr++;
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_group(input logic [31:0] grp);
        send_byte(grp[31:24]);
        send_byte(grp[23:16]);
        send_byte(grp[15:8]);
        send_byte(grp[7:0]);
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (exp_rd == exp_wr) break;
            @(negedge clk);
        end
    endtask

    // Output monitor: compares each accepted pixel with the expected list.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_rd >= exp_wr) begin
                check(1'b0, "R2/R8", "unexpected pixel", {8'h0, out_rgb}, 32'h0);
            end else begin
                check(out_rgb == exp_rgb[exp_rd], "R5/R6", "pixel rgb",
                      {8'h0, out_rgb}, {8'h0, exp_rgb[exp_rd]});
                check(out_eol == exp_eol[exp_rd], "R7", "end of row flag",
                      {31'h0, out_eol}, {31'h0, exp_eol[exp_rd]});
                check(out_eof == exp_eof[exp_rd], "R8", "end of frame flag",
                      {31'h0, out_eof}, {31'h0, exp_eof[exp_rd]});
                exp_rd++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);
        check({out_eol, out_eof} == 2'b00, "R1", "flags after reset",
              {30'h0, out_eol, out_eof}, 32'h0);
        @(negedge clk);

        // R2: junk (including a lone marker byte) is discarded
        send_byte(8'h33); send_byte(8'h10); send_byte(8'h55); send_byte(8'h22);
        send_byte(8'h10);
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R2", "no pixel from junk", {31'h0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R2", "ready while hunting", {31'h0, in_ready}, 32'h1);
        @(negedge clk);

        // R3/R4: overlapping marker 0x10,0x10,x,0x10 (preceded by 0x10 above)
        send_byte(8'h10); send_byte(8'h7F); send_byte(8'h10);

        // R5/R6/R7/R8: full frame from the table with output backpressure (R9)
        bp_auto = 1'b1;
        for (int k = 0; k < NPIX; k++) begin
            push_exp(PIX_TAB[k], (k % COLS) == COLS - 1, k == NPIX - 1);
            send_group(PIX_TAB[k]);
        end
        drain();
        check(exp_rd == exp_wr, "R5", "all frame pixels delivered", exp_rd, exp_wr);
        bp_auto = 1'b0;
        ready_man = 1'b1;
        @(negedge clk);

        // R8: bytes after the frame are hunted, not grouped
        send_byte(8'h20); send_byte(8'h21); send_byte(8'h22); send_byte(8'h23);
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R8", "no pixel after frame end", {31'h0, out_valid}, 32'h0);
        check(exp_rd == 12, "R8", "pixel count after frame end", exp_rd, 12);
        @(negedge clk);

        // R3: new marker with arbitrary middle byte relocks
        send_byte(8'h10); send_byte(8'h99); send_byte(8'h10);
        push_exp(32'h80_40_60_20, 1'b0, 1'b0);
        send_group(32'h80_40_60_20);
        drain();
        check(exp_rd == 13, "R3", "pixel after relock", exp_rd, 13);

        // R9/R10: stall with a completed group waiting
        ready_man = 1'b0;
        push_exp(32'h02_0B_04_0C, 1'b0, 1'b0);
        send_group(32'h02_0B_04_0C);
        #1;
        check(out_valid == 1'b1, "R10", "valid after red byte", {31'h0, out_valid}, 32'h1);
        check(out_rgb == 24'h0C_03_0B, "R6", "held pixel value", {8'h0, out_rgb}, 32'h000C030B);
        @(negedge clk);
        push_exp(32'hA0_B0_C0_D0, 1'b0, 1'b0);
        send_byte(8'hA0); send_byte(8'hB0); send_byte(8'hC0);
        check(1'b1, "R9", "three leading bytes accepted during stall", 32'h1, 32'h1);
        in_valid = 1'b1;
        in_data  = 8'hD0;
        #1;
        check(in_ready == 1'b0, "R9", "red byte refused while stalled", {31'h0, in_ready}, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        check(out_rgb == 24'h0C_03_0B, "R9", "pixel held while stalled", {8'h0, out_rgb}, 32'h000C030B);
        check(in_ready == 1'b0, "R9", "red byte still refused", {31'h0, in_ready}, 32'h0);
        ready_man = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        drain();
        check(exp_rd == 15, "R9", "both stalled pixels delivered", exp_rd, 15);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule